// File: doc/BRIEF.md
# Mixed-Width Memory Base Address Register Bank

This block holds the six memory base address registers of a device's configuration header, at dword offsets 4 through 9 (byte offsets 10h through 24h). Parameters set each slot as a plain 32-bit memory window, a 32-bit window that must sit below 1 MB, a 64-bit window that takes its own slot and the slot after it, or an unused slot. Each window is a power of two in size, at least 16 bytes. Writes are masked to the window size, so system software can write all ones, read back the size mask and then program a base address.

A 64-bit window is a single register that spans two slots. Only its lower dword carries the memory, type and prefetch attribute bits. The upper dword holds address bits 63:32 in full, and its low nibble is made of ordinary address bits. Alongside the register file, the block compares the current bus address against every programmed window. The address is either a 64-bit dual-address-cycle address, or a single-cycle address whose upper half is taken as zero. The block gives one hit flag per window, gated by a memory-space enable input.

Top module: `bar_bank`

## Requirements
- R1: After a synchronous reset, every writable bit of every slot is zero, so each slot reads back only its attribute bits.
- R2: A read returns its data on `cfg_rdata` at the clock edge that samples `cfg_rd_en`. A read of any dword offset outside 4 to 9 returns zero, and a write there changes nothing.
- R3: The lower dword of a used window reads bit 0 as 0 (memory) and bit 3 as the prefetch flag. Bits [2:1] read 00 for a 32-bit window, 01 for a below-1 MB window and 10 for a 64-bit window. Writes never change bits [3:0] of a lower dword.
- R4: Address bits below max(4, log2 size) read as zero whatever is written. Writing all ones to a lower dword reads back the size mask together with the attribute bits.
- R5: The upper dword of a 64-bit window (the slot after its lower dword) is writable in every bit position p for which 32+p is at least log2 size, including bits [3:0]. Bits [3:0] there are address bits 35:32 and carry no attributes.
- R6: A below-1 MB window has bits [31:20] read-only zero.
- R7: An unused slot reads zero, ignores writes and never hits.
- R8: Each bit of `cfg_byte_en` allows the write of its own byte lane of `cfg_wdata`. A disabled lane keeps its stored value.
- R9: A 64-bit window hits when the effective 64-bit address equals its programmed base in every bit at or above log2 size. The window may sit above 4 GB.
- R10: With `bus_dac` low, the upper 32 bits of `bus_addr` are ignored and the effective address has an upper half of zero. A 32-bit window never hits a dual-cycle address whose upper half is nonzero.
- R11: With `mem_space_en` low, every bit of `bar_hit` is zero.
- R12: Bit i of `bar_hit` can be set only when slot i holds a 32-bit window or the lower dword of a 64-bit window. The bit of an upper-dword slot and the bit of an unused slot stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration dword write strobe |
| cfg_rd_en | input | 1 | Configuration dword read strobe |
| cfg_dword | input | 6 | Dword offset within the header |
| cfg_byte_en | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| mem_space_en | input | 1 | Memory decode enable |
| bus_dac | input | 1 | 1: bus_addr is a full 64-bit address |
| bus_addr | input | 64 | Bus address |
| bar_hit | output | 6 | One hit flag per slot |

## Verification
A wrong stored bit shows up on the next read of its slot, one cycle after the strobe. It also moves a window, so the hit flags change in the same cycle as the address that exposes it. Mask errors are the hardest to see: a writable bit that should be read-only only shows after an all-ones write followed by a readback. Because of that, every slot is sized first and then read again after zeros are written. Upper-dword faults show only under dual-cycle addresses near the window edges and in the nibble for address bits 35:32. For that reason the decode tests probe just below the base, at the last byte of the window, and one step off in bit 32.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

    localparam int BAR_SLOTS   = 6;
    localparam int BAR_FIRST_DW = 4;
    localparam int SIZE_W      = 7;
    localparam int KIND_W      = 2;
    localparam int LOW1M_TOP   = 20;
    localparam int MIN_SIZE_LOG2 = 4;

    typedef enum logic [1:0] {
        KIND_NONE      = 2'd0,
        KIND_MEM32     = 2'd1,
        KIND_MEM32_LOW = 2'd2,
        KIND_MEM64     = 2'd3
    } bar_kind_e;

    typedef enum logic [2:0] {
        ROLE_OFF,
        ROLE_M32,
        ROLE_M32_LOW,
        ROLE_M64_LO,
        ROLE_M64_HI
    } slot_role_e;

    localparam logic [1:0] TYPE_ANY32 = 2'b00;
    localparam logic [1:0] TYPE_LOW1M = 2'b01;
    localparam logic [1:0] TYPE_ANY64 = 2'b10;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [5:0]  dword;
        logic [3:0]  be;
        logic [31:0] data;
    } cfg_req_t;

    typedef struct packed {
        logic        dac;
        logic [63:0] addr;
    } bus_req_t;

    // Walk the slots in order; a 64-bit kind claims the slot after it.
    function automatic slot_role_e role_of(logic [BAR_SLOTS*KIND_W-1:0] kinds, int idx);
        logic       claim_next;
        slot_role_e here;
        slot_role_e found;
        claim_next = 1'b0;
        found      = ROLE_OFF;
        for (int j = 0; j < BAR_SLOTS; j++) begin
            if (claim_next) begin
                here       = ROLE_M64_HI;
                claim_next = 1'b0;
            end else begin
                case (bar_kind_e'(kinds[j*KIND_W +: KIND_W]))
                    KIND_MEM32:     here = ROLE_M32;
                    KIND_MEM32_LOW: here = ROLE_M32_LOW;
                    KIND_MEM64: begin
                        if (j == BAR_SLOTS - 1) begin
                            here = ROLE_OFF;
                        end else begin
                            here       = ROLE_M64_LO;
                            claim_next = 1'b1;
                        end
                    end
                    default:        here = ROLE_OFF;
                endcase
            end
            if (j == idx) found = here;
        end
        return found;
    endfunction

    function automatic logic [31:0] slot_wmask(slot_role_e role, int own_sz, int prev_sz);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) begin
            case (role)
                ROLE_M32, ROLE_M64_LO: m[i] = (i >= MIN_SIZE_LOG2) && (i >= own_sz);
                ROLE_M32_LOW:          m[i] = (i >= MIN_SIZE_LOG2) && (i >= own_sz) && (i < LOW1M_TOP);
                ROLE_M64_HI:           m[i] = (i + 32 >= prev_sz);
                default:               m[i] = 1'b0;
            endcase
        end
        return m;
    endfunction

    function automatic logic [31:0] ro_bits(slot_role_e role, logic pref);
        case (role)
            ROLE_M32:     return {28'd0, pref, TYPE_ANY32, 1'b0};
            ROLE_M32_LOW: return {28'd0, pref, TYPE_LOW1M, 1'b0};
            ROLE_M64_LO:  return {28'd0, pref, TYPE_ANY64, 1'b0};
            default:      return 32'd0;
        endcase
    endfunction

    // Bits compared by the decoder; a 32-bit window also demands a zero upper half.
    function automatic logic [63:0] match_mask(slot_role_e role, int sz);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) begin
            if (role == ROLE_M64_LO)
                m[i] = (i >= MIN_SIZE_LOG2) && (i >= sz);
            else
                m[i] = (i >= 32) || ((i >= MIN_SIZE_LOG2) && (i >= sz));
        end
        return m;
    endfunction

    function automatic logic [BAR_SLOTS-1:0] silent_slots(logic [BAR_SLOTS*KIND_W-1:0] kinds);
        logic [BAR_SLOTS-1:0] s;
        for (int j = 0; j < BAR_SLOTS; j++) begin
            s[j] = (role_of(kinds, j) == ROLE_OFF) || (role_of(kinds, j) == ROLE_M64_HI);
        end
        return s;
    endfunction

    function automatic logic [BAR_SLOTS-1:0] off_slots(logic [BAR_SLOTS*KIND_W-1:0] kinds);
        logic [BAR_SLOTS-1:0] s;
        for (int j = 0; j < BAR_SLOTS; j++) s[j] = (role_of(kinds, j) == ROLE_OFF);
        return s;
    endfunction

endpackage

// File: rtl/bar_dword_reg.sv
module bar_dword_reg
    import bar_bank_pkg::*;
#(
    parameter logic [31:0] WMASK   = 32'd0,
    parameter logic [31:0] RO_BITS = 32'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rd_val
);

    localparam int LANES = 4;

    logic [31:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (be[b]) q[b*8 +: 8] <= wdata[b*8 +: 8] & WMASK[b*8 +: 8];
            end
        end
    end

    assign rd_val = q | RO_BITS;

    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (q == '0));

    for (genvar b = 0; b < LANES; b++) begin : g_lane_chk
        assert_lane_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (!wr_en || !be[b]) |=> $stable(rd_val[b*8 +: 8]));
    end

endmodule

// File: rtl/bar_window_match.sv
module bar_window_match
    import bar_bank_pkg::*;
#(
    parameter slot_role_e ROLE      = ROLE_OFF,
    parameter int         SIZE_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] base_lo,
    input  logic [31:0] base_hi,
    input  logic [63:0] addr,
    output logic        hit
);

    localparam logic        WIDE    = (ROLE == ROLE_M64_LO);
    localparam logic        DECODES = (ROLE == ROLE_M32) || (ROLE == ROLE_M32_LOW) || WIDE;
    localparam logic [63:0] MASK    = match_mask(ROLE, SIZE_LOG2);
    localparam logic        SMALL   = (SIZE_LOG2 <= 32);

    logic [63:0] ref_base;

    always_comb begin
        ref_base = {WIDE ? base_hi : 32'd0, base_lo};
        hit      = DECODES && (((addr ^ ref_base) & MASK) == 64'd0);
    end

    assert_narrow_upper_R10: assert property (@(posedge clk) disable iff (rst)
        (hit && !WIDE) |-> (addr[63:32] == 32'd0));

    assert_wide_upper_R9: assert property (@(posedge clk) disable iff (rst)
        (hit && WIDE && SMALL) |-> (addr[63:32] == base_hi));

endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_bank_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter logic [BAR_SLOTS*KIND_W-1:0] SLOT_KINDS =
        {KIND_MEM32, KIND_NONE, KIND_MEM32_LOW, KIND_MEM32, KIND_NONE, KIND_MEM64},
    parameter logic [BAR_SLOTS*SIZE_W-1:0] SLOT_SIZE_LOG2 =
        {7'd16, 7'd0, 7'd8, 7'd12, 7'd0, 7'd31},
    parameter logic [BAR_SLOTS-1:0] SLOT_PREFETCH = 6'b000001
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_rd_en,
    input  logic [CFG_AW-1:0]    cfg_dword,
    input  logic [3:0]           cfg_byte_en,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 mem_space_en,
    input  logic                 bus_dac,
    input  logic [63:0]          bus_addr,
    output logic [BAR_SLOTS-1:0] bar_hit
);

    localparam logic [BAR_SLOTS-1:0] SILENT = silent_slots(SLOT_KINDS);
    localparam logic [BAR_SLOTS-1:0] UNUSED = off_slots(SLOT_KINDS);
    localparam logic [CFG_AW-1:0]    DW_LO  = CFG_AW'(BAR_FIRST_DW);
    localparam logic [CFG_AW-1:0]    DW_HI  = CFG_AW'(BAR_FIRST_DW + BAR_SLOTS - 1);

    cfg_req_t             req;
    bus_req_t             bus;
    logic [63:0]          eff_addr;
    logic [BAR_SLOTS-1:0] wr_sel;
    logic [BAR_SLOTS-1:0] raw_hit;
    logic [31:0]          slot_val [BAR_SLOTS];
    logic [31:0]          rd_mux;

    always_comb begin
        req = '{wr: cfg_wr_en, rd: cfg_rd_en, dword: 6'(cfg_dword), be: cfg_byte_en, data: cfg_wdata};
        bus = '{dac: bus_dac, addr: bus_addr};
        eff_addr = bus.dac ? bus.addr : {32'd0, bus.addr[31:0]};
    end

    always_comb begin
        for (int s = 0; s < BAR_SLOTS; s++) begin
            wr_sel[s] = req.wr && (cfg_dword == CFG_AW'(BAR_FIRST_DW + s));
        end
    end

    for (genvar s = 0; s < BAR_SLOTS; s++) begin : g_slot
        localparam slot_role_e  ROLE    = role_of(SLOT_KINDS, s);
        localparam int          PREV    = (s > 0) ? s - 1 : 0;
        localparam int          NEXT    = (s + 1 < BAR_SLOTS) ? s + 1 : s;
        localparam int          OWN_SZ  = int'(SLOT_SIZE_LOG2[s*SIZE_W +: SIZE_W]);
        localparam int          PREV_SZ = int'(SLOT_SIZE_LOG2[PREV*SIZE_W +: SIZE_W]);
        localparam logic [31:0] WMASK   = slot_wmask(ROLE, OWN_SZ, PREV_SZ);
        localparam logic [31:0] RO      = ro_bits(ROLE, SLOT_PREFETCH[s]);

        bar_dword_reg #(
            .WMASK   (WMASK),
            .RO_BITS (RO)
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_sel[s]),
            .be     (req.be),
            .wdata  (req.data),
            .rd_val (slot_val[s])
        );

        bar_window_match #(
            .ROLE      (ROLE),
            .SIZE_LOG2 (OWN_SZ)
        ) u_match (
            .clk     (clk),
            .rst     (rst),
            .base_lo (slot_val[s]),
            .base_hi (slot_val[NEXT]),
            .addr    (eff_addr),
            .hit     (raw_hit[s])
        );
    end

    always_comb begin
        rd_mux = 32'd0;
        for (int s = 0; s < BAR_SLOTS; s++) begin
            if (cfg_dword == CFG_AW'(BAR_FIRST_DW + s)) rd_mux = slot_val[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= 32'd0;
        end else if (req.rd) begin
            cfg_rdata <= rd_mux;
        end
    end

    assign bar_hit = mem_space_en ? raw_hit : '0;

    assert_outside_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_en && ((cfg_dword < DW_LO) || (cfg_dword > DW_HI))) |=> (cfg_rdata == 32'd0));

    assert_unused_read_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_en && (cfg_dword >= DW_LO) && (cfg_dword <= DW_HI)
         && UNUSED[cfg_dword - DW_LO]) |=> (cfg_rdata == 32'd0));

    assert_silent_slots_R12: assert property (@(posedge clk) disable iff (rst)
        ((bar_hit & SILENT) == '0));

    assert_gate_R11: assert property (@(posedge clk) disable iff (rst)
        !mem_space_en |-> (bar_hit == '0));

endmodule

// File: tb/test_bar_bank.sv
module test_bar_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic [5:0]  cfg_dword = '0;
    logic [3:0]  cfg_byte_en = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_space_en = 1'b0;
    logic        bus_dac = 1'b0;
    logic [63:0] bus_addr = '0;
    logic [5:0]  bar_hit;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bar_bank i_bar_bank (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_rd_en    (cfg_rd_en),
        .cfg_dword    (cfg_dword),
        .cfg_byte_en  (cfg_byte_en),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .mem_space_en (mem_space_en),
        .bus_dac      (bus_dac),
        .bus_addr     (bus_addr),
        .bar_hit      (bar_hit)
    );

    task automatic check32(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_dword = dw; cfg_byte_en = be; cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_byte_en = 4'h0;
    endtask

    task automatic read_check(input string req, input logic [5:0] dw, input logic [31:0] exp);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_dword = dw;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        check32(req, cfg_rdata, exp);
    endtask

    task automatic hit_check(input string req, input logic en, input logic dac,
                             input logic [63:0] addr, input logic [5:0] exp);
        @(negedge clk);
        mem_space_en = en; bus_dac = dac; bus_addr = addr;
        #2;
        check32(req, {26'd0, bar_hit}, {26'd0, exp});
    endtask

    // Layout: slot0-1 64-bit 2GB prefetchable, slot2 32-bit 4KB,
    // slot3 below-1MB 256B, slot4 unused, slot5 32-bit 64KB.
    task automatic t_reset;
        read_check("R1 R3 slot0 reset", 6'd4, 32'h0000_000C);
        read_check("R1 R5 slot1 reset", 6'd5, 32'h0000_0000);
        read_check("R1 R3 slot2 reset", 6'd6, 32'h0000_0000);
        read_check("R1 R3 slot3 reset", 6'd7, 32'h0000_0002);
        read_check("R1 R7 slot4 reset", 6'd8, 32'h0000_0000);
        read_check("R1 slot5 reset",    6'd9, 32'h0000_0000);
        hit_check("R11 gated after reset", 1'b0, 1'b0, 64'h0, 6'b000000);
    endtask

    task automatic t_sizing;
        for (int d = 4; d <= 9; d++) cfg_write(6'(d), 4'hF, 32'hFFFF_FFFF);
        read_check("R4 R3 slot0 size",     6'd4, 32'h8000_000C);
        read_check("R5 slot1 upper size",  6'd5, 32'hFFFF_FFFF);
        read_check("R4 slot2 size",        6'd6, 32'hFFFF_F000);
        read_check("R6 R4 slot3 size",     6'd7, 32'h000F_FF02);
        read_check("R7 slot4 ignores",     6'd8, 32'h0000_0000);
        read_check("R4 slot5 size",        6'd9, 32'hFFFF_0000);
        for (int d = 4; d <= 9; d++) cfg_write(6'(d), 4'hF, 32'h0000_0000);
        read_check("R3 slot0 attr kept",   6'd4, 32'h0000_000C);
        read_check("R3 slot3 attr kept",   6'd7, 32'h0000_0002);
        read_check("R5 slot1 cleared",     6'd5, 32'h0000_0000);
    endtask

    task automatic t_outside;
        cfg_write(6'd3, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd10, 4'hF, 32'hFFFF_FFFF);
        read_check("R2 offset 3 zero",  6'd3,  32'h0);
        read_check("R2 offset 10 zero", 6'd10, 32'h0);
        read_check("R2 slot2 untouched", 6'd6, 32'h0);
    endtask

    task automatic t_byte_lanes;
        cfg_write(6'd6, 4'b0100, 32'hAABB_CCDD);
        read_check("R8 lane2 only", 6'd6, 32'h00BB_0000);
        cfg_write(6'd6, 4'b0001, 32'h1234_5678);
        read_check("R8 R4 lane0 masked", 6'd6, 32'h00BB_0000);
        cfg_write(6'd6, 4'b0010, 32'h1234_5678);
        read_check("R8 R4 lane1 partial", 6'd6, 32'h00BB_5000);
        cfg_write(6'd5, 4'b0001, 32'h0000_0005);
        read_check("R5 R8 upper nibble writable", 6'd5, 32'h0000_0005);
    endtask

    task automatic t_decode;
        cfg_write(6'd4, 4'hF, 32'h8000_0000);
        cfg_write(6'd5, 4'hF, 32'h0000_0005);
        cfg_write(6'd6, 4'hF, 32'h1234_5000);
        cfg_write(6'd7, 4'hF, 32'h0ABC_DE00);
        cfg_write(6'd8, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd9, 4'hF, 32'hFFFF_0000);
        read_check("R6 slot3 high bits dropped", 6'd7, 32'h000C_DE02);
        hit_check("R9 64-bit base",        1'b1, 1'b1, 64'h0000_0005_8000_0010, 6'b000001);
        hit_check("R9 64-bit last byte",   1'b1, 1'b1, 64'h0000_0005_FFFF_FFFF, 6'b000001);
        hit_check("R9 64-bit below base",  1'b1, 1'b1, 64'h0000_0005_7FFF_FFFF, 6'b000000);
        hit_check("R9 R5 bit32 differs",   1'b1, 1'b1, 64'h0000_0004_8000_0000, 6'b000000);
        hit_check("R10 upper ignored SAC", 1'b1, 1'b0, 64'h0000_0005_8000_0000, 6'b000000);
        hit_check("R12 slot2 SAC",         1'b1, 1'b0, 64'h0000_0000_1234_5FFC, 6'b000100);
        hit_check("R10 slot2 DAC high",    1'b1, 1'b1, 64'h0000_0001_1234_5000, 6'b000000);
        hit_check("R12 slot2 past end",    1'b1, 1'b0, 64'h0000_0000_1234_6000, 6'b000000);
        hit_check("R6 slot3 hit",          1'b1, 1'b0, 64'h0000_0000_000C_DE7F, 6'b001000);
        hit_check("R7 R12 slot5 hit",      1'b1, 1'b0, 64'h0000_0000_FFFF_1234, 6'b100000);
        hit_check("R11 disabled",          1'b0, 1'b0, 64'h0000_0000_1234_5000, 6'b000000);
        hit_check("R11 disabled DAC",      1'b0, 1'b1, 64'h0000_0005_8000_0000, 6'b000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sizing();
        t_outside();
        t_byte_lanes();
        t_decode();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule